// File: doc/BRIEF.md
# Interleaved Switching Clock Generator

This block derives the switching-cycle clock of a synchronous buck controller from a fast system clock. Each switching cycle begins with a one-clock start pulse. The cycle length is set by a programmable count of system clocks, so the nominal rate (for example 300 kHz) depends only on the value programmed.

The block takes one of three roles, chosen by a two-bit role input. As master it runs from its own counter and drives a sync output. As slave it measures the spacing of rising edges on the sync input and places its own cycle starts half a spacing after each edge, so that two converters switch in antiphase. A slave that sees no sync edges runs from its internal counter, which also covers standalone use with the sync line tied low.

An external comparator can raise a transient flag. If the enhancement is enabled, a rising edge of the flag halves the cycle length for a window of one nominal period, and the cycle length then returns to normal.

Top module: `pwm_phase_clk`

## Requirements
- R1: Role codes 2'b00 and 2'b11 disable the block. After any clock edge that samples a disabling code, `cyc_start_o`, `sync_o` and `locked_o` are low, and `sync_i` and the transient flag have no effect on them.
- R2: In an active role (2'b01 master, 2'b10 slave) with no alignment and no burst, `cyc_start_o` is a one-clock pulse that repeats every `period_i` clocks, for `period_i` >= 4. The first pulse follows the first edge that samples an active role.
- R3: In master role `sync_o` is high for the first floor(L/2) clocks of each cycle of length L. It rises in the same cycle as `cyc_start_o`.
- R4: In master role `sync_i` has no effect on the cycle timing. In slave role `sync_o` stays low.
- R5: A slave that has seen fewer than two sync rising edges runs from its internal counter at `period_i`, with `locked_o` low.
- R6: In slave role the first rising edge of `sync_i` only arms the tracker. Every later rising edge sets `locked_o` after the edge that samples it. It also places a cycle start floor(M/2) clocks after that edge, where M is the number of clocks since the previous rising edge.
- R7: If no sync rising edge is sampled for 2*`period_i` clocks, `locked_o` falls exactly 2*`period_i` clocks after the last edge. The tracker disarms, and the cycle continues from the internal counter at `period_i`.
- R8: With `boost_en_i` high, a rising edge of `boost_flag_i` sampled at edge b sets the cycle length to floor(`period_i`/2) for edges b+1 through b+`period_i`. A counter already past the short limit wraps at the next edge.
- R9: A burst is started only by a rising edge of the flag that arrives while no burst is running. Holding the flag high does not start a second burst. A rising edge inside the window neither extends nor restarts it.
- R10: With `boost_en_i` low the transient flag has no effect on the cycle timing.
- R11: An active-low asynchronous reset forces all outputs low at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| role_i | input | 2 | Role: 00 off, 01 master, 10 slave, 11 off |
| period_i | input | PER_W | Nominal cycle length in system clocks |
| sync_i | input | 1 | Sync clock from the master (used in slave role) |
| boost_en_i | input | 1 | Enables the transient burst function |
| boost_flag_i | input | 1 | Transient flag from the external comparator |
| cyc_start_o | output | 1 | One-clock pulse at the start of each switching cycle |
| sync_o | output | 1 | Sync clock to a slave (master role only) |
| locked_o | output | 1 | Slave is aligned to the incoming sync clock |

## Verification
The properties assume that `sync_i` is already synchronous to `clk` and that `period_i` is at least 4 and does not change while a role is active. They also assume that the role changes only between clean clock edges. The bench drives every input two nanoseconds after a rising edge and uses periods from 6 upward. It changes the period only while the block is disabled, and it shapes sync pulses of at least three clocks so that each rising edge is seen exactly once.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    typedef enum logic [1:0] {
        ROLE_OFF    = 2'b00,
        ROLE_MASTER = 2'b01,
        ROLE_SLAVE  = 2'b10,
        ROLE_PARK   = 2'b11
    } role_e;

endpackage

// File: rtl/pwm_sync_track.sv
module pwm_sync_track #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sync_i,
    input  logic [PER_W-1:0] period_i,
    output logic             realign_o,
    output logic [PER_W-1:0] half_o,
    output logic             locked_o
);
    localparam int GAP_W = PER_W + 1;
    localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

    typedef struct packed {
        logic             prev;
        logic             armed;
        logic             lock;
        logic [GAP_W-1:0] gap;
    } trk_t;

    trk_t trk_q, trk_d;
    logic             rise;
    logic [GAP_W-1:0] limit;

    always_comb begin
        rise      = en_i && sync_i && !trk_q.prev;
        limit     = {period_i, 1'b0} - GAP_ONE;
        // half of (gap + 1), the spacing between the last two edges
        half_o    = trk_q.gap[GAP_W-1:1] + {{(PER_W-1){1'b0}}, trk_q.gap[0]};
        realign_o = rise && trk_q.armed;

        trk_d      = trk_q;
        trk_d.prev = sync_i;
        if (!en_i) begin
            trk_d.armed = 1'b0;
            trk_d.lock  = 1'b0;
            trk_d.gap   = '0;
        end else if (rise) begin
            trk_d.gap   = '0;
            trk_d.armed = 1'b1;
            trk_d.lock  = trk_q.armed;
        end else if (trk_q.gap >= limit) begin
            trk_d.armed = 1'b0;
            trk_d.lock  = 1'b0;
        end else begin
            trk_d.gap = trk_q.gap + GAP_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign locked_o = trk_q.lock;

endmodule

// File: rtl/pwm_boost_win.sv
module pwm_boost_win #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             flag_i,
    input  logic [PER_W-1:0] period_i,
    output logic             burst_o
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    typedef struct packed {
        logic             prev;
        logic [PER_W-1:0] left;
    } win_t;

    win_t win_q, win_d;
    logic start;

    always_comb begin
        start      = en_i && flag_i && !win_q.prev && (win_q.left == '0);
        win_d      = win_q;
        win_d.prev = flag_i;
        if (!en_i)                win_d.left = '0;
        else if (start)           win_d.left = period_i;
        else if (win_q.left != '0) win_d.left = win_q.left - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign burst_o = (win_q.left != '0);

endmodule

// File: rtl/pwm_phase_clk.sv
module pwm_phase_clk #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       role_i,
    input  logic [PER_W-1:0] period_i,
    input  logic             sync_i,
    input  logic             boost_en_i,
    input  logic             boost_flag_i,
    output logic             cyc_start_o,
    output logic             sync_o,
    output logic             locked_o
);
    import pwm_phase_pkg::*;

    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic             start;
        logic             sync;
    } cyc_t;

    role_e            role;
    logic             is_master, is_slave, active;
    logic             realign, burst;
    logic [PER_W-1:0] half, lim, lim_last;
    cyc_t             cyc_q, cyc_d;

    assign role      = role_e'(role_i);
    assign is_master = (role == ROLE_MASTER);
    assign is_slave  = (role == ROLE_SLAVE);
    assign active    = is_master || is_slave;

    pwm_sync_track #(.PER_W(PER_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (is_slave),
        .sync_i    (sync_i),
        .period_i  (period_i),
        .realign_o (realign),
        .half_o    (half),
        .locked_o  (locked_o)
    );

    pwm_boost_win #(.PER_W(PER_W)) u_boost (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (active && boost_en_i),
        .flag_i   (boost_flag_i),
        .period_i (period_i),
        .burst_o  (burst)
    );

    always_comb begin
        lim      = burst ? (period_i >> 1) : period_i;
        lim_last = lim - ONE;
        cyc_d    = cyc_q;
        if (!active) begin
            // parked one short of wrap: first active edge starts a cycle
            cyc_d.cnt   = period_i - ONE;
            cyc_d.start = 1'b0;
            cyc_d.sync  = 1'b0;
        end else begin
            if (realign) begin
                cyc_d.cnt   = period_i - half;
                cyc_d.start = 1'b0;
            end else if (cyc_q.cnt >= lim_last) begin
                cyc_d.cnt   = '0;
                cyc_d.start = 1'b1;
            end else begin
                cyc_d.cnt   = cyc_q.cnt + ONE;
                cyc_d.start = 1'b0;
            end
            cyc_d.sync = is_master && (cyc_d.cnt < (lim >> 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else        cyc_q <= cyc_d;
    end

    assign cyc_start_o = cyc_q.start;
    assign sync_o      = cyc_q.sync;

endmodule

// File: rtl/pwm_phase_clk_chk.sv
module pwm_phase_clk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] role_i,
    input logic       sync_i,
    input logic       cyc_start_o,
    input logic       sync_o,
    input logic       locked_o
);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (role_i == 2'b00 || role_i == 2'b11) |=> (!cyc_start_o && !sync_o && !locked_o)); // R1

    AST_START_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |=> !cyc_start_o); // R2

    AST_START_WITH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start_o && $past(role_i) == 2'b01) |-> sync_o); // R3

    AST_SLAVE_NO_SYNC_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(role_i) == 2'b10) |-> !sync_o); // R4

    AST_LOCK_IN_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> ($past(role_i) == 2'b10)); // R6

    AST_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> ($past(sync_i) && !$past(sync_i, 2))); // R6

endmodule

bind pwm_phase_clk pwm_phase_clk_chk u_chk (.*);

// File: tb/pwm_phase_clk_test.sv
module pwm_phase_clk_test;

    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    role_i = 2'b00;
    logic [PW-1:0] period_i = 16;
    logic          sync_i = 1'b0;
    logic          boost_en_i = 1'b0;
    logic          boost_flag_i = 1'b0;
    logic          cyc_start_o, sync_o, locked_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int npulse = 0;
    int pulse_at [0:1023];
    int slave_sync_hi = 0;

    always #4 clk = ~clk;

    pwm_phase_clk #(.PER_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .role_i(role_i), .period_i(period_i),
        .sync_i(sync_i), .boost_en_i(boost_en_i), .boost_flag_i(boost_flag_i),
        .cyc_start_o(cyc_start_o), .sync_o(sync_o), .locked_o(locked_o)
    );

    task automatic step();
        @(posedge clk);
        #2;
        cyc++;
        if (cyc_start_o) begin
            if (npulse < 1024) pulse_at[npulse] = cyc;
            npulse++;
        end
        if (role_i == 2'b10 && sync_o) slave_sync_hi++;
    endtask

    task automatic step_to(int t);
        while (cyc < t) step();
    endtask

    function automatic bit has_pulse(int t);
        for (int i = 0; i < npulse && i < 1024; i++)
            if (pulse_at[i] == t) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int pulses_in(int lo, int hi);
        int n = 0;
        for (int i = 0; i < npulse && i < 1024; i++)
            if (pulse_at[i] > lo && pulse_at[i] <= hi) n++;
        return n;
    endfunction

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic slave_train(int m, int p);
        int e [4];
        int h = m / 2;
        for (int k = 0; k < 4; k++) begin
            sync_i = 1'b1;
            e[k] = cyc + 1;
            step();
            if (k == 0) check_eq("R6 first edge only arms", int'(locked_o), 0);
            if (k == 1) check_eq("R6 lock on second edge", int'(locked_o), 1);
            step(); step();
            sync_i = 1'b0;
            repeat (m - 3) step();
        end
        for (int k = 1; k < 4; k++)
            check_eq("R6 start half spacing after edge", int'(has_pulse(e[k] + h)), 1);
        check_eq("R6 no extra starts", pulses_in(e[1], e[3] + h), 3);
        step_to(e[3] + 2 * p - 1);
        check_eq("R7 lock held before timeout", int'(locked_o), 1);
        step();
        check_eq("R7 lock drops at timeout", int'(locked_o), 0);
        step_to(e[3] + h + 3 * p + 1);
        check_eq("R7 free run after loss", pulses_in(e[3] + h, e[3] + h + 3 * p), 3);
        check_eq("R7 free run spacing", int'(has_pulse(e[3] + h + 3 * p)), 1);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c, p, p2, p3, base, sh, mis, hi;
        int plist [4] = '{6, 9, 16, 21};

        // reset state
        repeat (3) step();
        check_eq("R11 outputs low in reset", int'({cyc_start_o, sync_o, locked_o}), 0);
        rst_n = 1'b1;
        step();

        // master sweep over periods, sync_i toggling (ignored)
        foreach (plist[j]) begin
            role_i = 2'b00; period_i = PW'(plist[j]);
            repeat (3) step();
            role_i = 2'b01;
            c = cyc; base = npulse; sh = 0; mis = 0;
            for (int i = 0; i < 3 * plist[j] + 1; i++) begin
                sync_i = ~sync_i;
                step();
                if (cyc <= c + 3 * plist[j] && sync_o) sh++;
                if (cyc_start_o && !sync_o) mis++;
            end
            check_eq("R2 first start", pulse_at[base], c + 1);
            check_eq("R2 start count", npulse - base, 4);
            check_eq("R2 R4 spacing", pulse_at[base + 3] - pulse_at[base], 3 * plist[j]);
            check_eq("R3 sync high clocks", sh, 3 * (plist[j] / 2));
            check_eq("R3 sync rises with start", mis, 0);
        end
        sync_i = 1'b0;

        // disable codes with busy inputs
        foreach (plist[j]) begin
            if (j < 2) begin
                role_i = (j == 0) ? 2'b00 : 2'b11;
                boost_en_i = 1'b1;
                hi = 0;
                for (int i = 0; i < 30; i++) begin
                    sync_i = ~sync_i; boost_flag_i = (i % 3) == 0;
                    step();
                    if (cyc_start_o || sync_o || locked_o) hi++;
                end
                check_eq("R1 outputs quiet when off", hi, 0);
            end
        end
        sync_i = 1'b0; boost_flag_i = 1'b0; boost_en_i = 1'b0;

        // slave, sync held low: standalone
        role_i = 2'b00; period_i = 16;
        repeat (3) step();
        role_i = 2'b10;
        c = cyc; base = npulse; hi = 0;
        for (int i = 0; i < 33; i++) begin
            step();
            if (locked_o) hi++;
        end
        check_eq("R5 first start", pulse_at[base], c + 1);
        check_eq("R5 internal spacing", pulse_at[base + 2], c + 33);
        check_eq("R5 unlocked", hi, 0);
        slave_train(12, 16);
        slave_train(15, 16);
        check_eq("R4 slave sync_o low", slave_sync_hi, 0);

        // burst with bounce inside the window
        role_i = 2'b00; boost_en_i = 1'b1; boost_flag_i = 1'b0;
        repeat (3) step();
        role_i = 2'b01;
        c = cyc;
        p = c + 17;
        step_to(p);
        boost_flag_i = 1'b1;
        step_to(p + 3); boost_flag_i = 1'b0;
        step_to(p + 5); boost_flag_i = 1'b1;
        step_to(p + 50);
        check_eq("R8 short cycle 1", int'(has_pulse(p + 8)), 1);
        check_eq("R8 short cycle 2", int'(has_pulse(p + 16)), 1);
        check_eq("R9 window not extended", int'(has_pulse(p + 32)), 1);
        check_eq("R9 no second burst", pulses_in(p, p + 48), 4);

        // enhancement disabled
        boost_en_i = 1'b0; boost_flag_i = 1'b0;
        p2 = p + 64;
        step_to(p2);
        boost_flag_i = 1'b1;
        step_to(p2 + 34);
        check_eq("R10 flag ignored", pulses_in(p2, p2 + 32), 2);
        check_eq("R10 normal spacing", int'(has_pulse(p2 + 16)), 1);

        // enable with flag already high: no burst, then a fresh edge
        boost_en_i = 1'b1;
        p3 = p2 + 48;
        step_to(p3);
        check_eq("R9 held flag starts nothing", int'(has_pulse(p3)), 1);
        boost_flag_i = 1'b0;
        step();
        boost_flag_i = 1'b1;
        step_to(p3 + 34);
        check_eq("R8 fresh edge bursts", int'(has_pulse(p3 + 8)), 1);
        check_eq("R8 burst pattern", pulses_in(p3, p3 + 32), 3);

        // asynchronous reset in mid-cycle
        boost_flag_i = 1'b0;
        step();
        while (!cyc_start_o) step();
        check_eq("R3 sync high at start", int'(sync_o), 1);
        rst_n = 1'b0;
        #1;
        check_eq("R11 async clear", int'({cyc_start_o, sync_o, locked_o}), 0);
        step();
        rst_n = 1'b1;
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule